// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block chooses the next control-memory address for a microprogrammed control unit. It holds a 7-bit control address register and a one-entry subroutine return register. On every clock it reads three fields of the microinstruction that is currently executing: a 2-bit branch kind, a 2-bit condition selector and a 7-bit target address. It also reads the opcode and indirect bits of the instruction data word and two accumulator flags.

The condition selector picks one test bit. The branch kind and that bit then select one of four sources for the next address: the incremented address, the target address, the saved return address, or an address built from the opcode. The opcode address gives every opcode a routine slot of four words. A taken call saves the incremented address, and a return jumps back to it.

Reset places the register at the start of the fetch routine. The control memory, the decoding of the microoperation fields and the datapath are outside this block.

Top module: `umseq_sequencer`

## Requirements
- R1: A synchronous active-high reset sets the control address to 64 and clears the return register, so a return issued straight after reset goes to address 0.
- R2: Branch kind 00 (jump) loads the target address when the selected condition is true.
- R3: Branch kinds 00 (jump) and 01 (call) load the current address plus one when the selected condition is false.
- R4: Branch kind 01 (call) with a true condition loads the target address and saves the current address plus one in the return register.
- R5: Branch kind 10 (return) loads the address held in the return register, whatever the condition.
- R6: Branch kind 11 (map) loads an address whose bits [5:2] are data word bits [14:11] and whose bits 6, 1 and 0 are zero, whatever the condition.
- R7: Condition selector 00 is always true, 01 is data word bit 15, 10 is the accumulator sign input and 11 is the accumulator zero input.
- R8: The incremented address wraps from 127 to 0.
- R9: Only a call with a true condition changes the return register. Jumps, calls that are not taken, returns and maps leave it unchanged.
- R10: A fetch routine of two unconditional jumps and a map produces the address trace 64, 65, 66, and then the mapped opcode address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_kind | input | 2 | Branch kind of the current microinstruction |
| cond_sel | input | 2 | Condition selector of the current microinstruction |
| target_addr | input | 7 | Address field of the current microinstruction |
| instr_word | input | 16 | Instruction data word; bit 15 is the indirect bit and bits [14:11] are the opcode |
| acc_sign | input | 1 | Accumulator sign flag |
| acc_zero | input | 1 | Accumulator zero flag |
| ctrl_addr | output | 7 | Current control address, which is sent to the control memory |

## Verification
The bench uses the default parameters: a 7-bit address, a 16-bit data word and a 4-bit opcode mapped at bit 2. The address space is only 128 words, so the sweep can drive every branch kind with every condition selector and both truth values of the selected flag, starting from addresses spread across the whole space, the top address included. After each tested microinstruction the bench issues a return, so the return register becomes visible at the output. This makes every update of that register, and every case that must leave it unchanged, observable. A short behavioural microprogram then replays the fetch routine and an indirect call followed by its return.

// File: rtl/umseq_pkg.sv
package umseq_pkg;

    typedef enum logic [1:0] {
        BR_JUMP   = 2'b00,
        BR_CALL   = 2'b01,
        BR_RETURN = 2'b10,
        BR_MAP    = 2'b11
    } br_kind_e;

    typedef enum logic [1:0] {
        CS_ALWAYS   = 2'b00,
        CS_INDIRECT = 2'b01,
        CS_NEGATIVE = 2'b10,
        CS_ZERO     = 2'b11
    } cond_src_e;

    // next-address source select
    typedef enum logic [1:0] {
        SRC_INC    = 2'b00,
        SRC_TARGET = 2'b01,
        SRC_RETURN = 2'b10,
        SRC_MAPPED = 2'b11
    } src_sel_e;

endpackage

// File: rtl/umseq_cond_pick.sv
module umseq_cond_pick
    import umseq_pkg::*;
(
    input  logic [1:0] cond_sel,
    input  logic       ind_bit,
    input  logic       acc_sign,
    input  logic       acc_zero,
    output logic       cond_true
);
    logic [3:0] cand;

    always_comb begin
        cand[CS_ALWAYS]   = 1'b1;
        cand[CS_INDIRECT] = ind_bit;
        cand[CS_NEGATIVE] = acc_sign;
        cand[CS_ZERO]     = acc_zero;
        cond_true         = cand[cond_sel];
    end
endmodule

// File: rtl/umseq_map.sv
module umseq_map #(
    parameter int unsigned ADDR_W    = 7,
    parameter int unsigned OPC_W     = 4,
    parameter int unsigned MAP_SHIFT = 2
) (
    input  logic [OPC_W-1:0]  opcode,
    output logic [ADDR_W-1:0] mapped
);
    localparam int unsigned TOP_BIT = MAP_SHIFT + OPC_W;

    generate
        if (TOP_BIT > ADDR_W) begin : g_bad_cfg
            initial $error("umseq_map: opcode slot exceeds address width");
        end
    endgenerate

    always_comb begin
        mapped                    = '0;
        mapped[MAP_SHIFT +: OPC_W] = opcode;
    end
endmodule

// File: rtl/umseq_next_addr.sv
module umseq_next_addr
    import umseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  logic [1:0]        br_kind,
    input  logic              cond_true,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic [ADDR_W-1:0] mapped_addr,
    output logic [ADDR_W-1:0] inc_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic              save_ret
);
    logic     s1, s0;
    src_sel_e sel;

    always_comb begin
        inc_addr = cur_addr + ADDR_W'(1);
        s1       = br_kind[1];
        s0       = (br_kind[1] & br_kind[0]) | (~br_kind[1] & cond_true);
        save_ret = ~br_kind[1] & br_kind[0] & cond_true;
        sel      = src_sel_e'({s1, s0});
        unique case (sel)
            SRC_INC:    next_addr = inc_addr;
            SRC_TARGET: next_addr = target_addr;
            SRC_RETURN: next_addr = ret_addr;
            default:    next_addr = mapped_addr;
        endcase
    end
endmodule

// File: rtl/umseq_sequencer.sv
module umseq_sequencer
    import umseq_pkg::*;
#(
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned OPC_W      = 4,
    parameter int unsigned OPC_LSB    = 11,
    parameter int unsigned MAP_SHIFT  = 2,
    parameter int unsigned FETCH_ADDR = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        br_kind,
    input  logic [1:0]        cond_sel,
    input  logic [ADDR_W-1:0] target_addr,
    input  logic [DATA_W-1:0] instr_word,
    input  logic              acc_sign,
    input  logic              acc_zero,
    output logic [ADDR_W-1:0] ctrl_addr
);
    localparam int unsigned        IND_BIT    = DATA_W - 1;
    localparam logic [ADDR_W-1:0]  RESET_ADDR = ADDR_W'(FETCH_ADDR);

    typedef struct packed {
        logic [ADDR_W-1:0] car;
        logic [ADDR_W-1:0] sbr;
    } seq_state_t;

    seq_state_t        state_d, state_q;
    logic              cond_true, save_ret;
    logic [ADDR_W-1:0] mapped_addr, inc_addr, next_addr;

    umseq_cond_pick u_cond (
        .cond_sel  (cond_sel),
        .ind_bit   (instr_word[IND_BIT]),
        .acc_sign  (acc_sign),
        .acc_zero  (acc_zero),
        .cond_true (cond_true)
    );

    umseq_map #(
        .ADDR_W    (ADDR_W),
        .OPC_W     (OPC_W),
        .MAP_SHIFT (MAP_SHIFT)
    ) u_map (
        .opcode (instr_word[OPC_LSB +: OPC_W]),
        .mapped (mapped_addr)
    );

    umseq_next_addr #(
        .ADDR_W (ADDR_W)
    ) u_next (
        .br_kind     (br_kind),
        .cond_true   (cond_true),
        .cur_addr    (state_q.car),
        .target_addr (target_addr),
        .ret_addr    (state_q.sbr),
        .mapped_addr (mapped_addr),
        .inc_addr    (inc_addr),
        .next_addr   (next_addr),
        .save_ret    (save_ret)
    );

    always_comb begin
        state_d     = state_q;
        state_d.car = next_addr;
        if (save_ret) begin
            state_d.sbr = inc_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q.car <= RESET_ADDR;
            state_q.sbr <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ctrl_addr = state_q.car;
endmodule

// File: rtl/umseq_checker.sv
module umseq_checker #(
    parameter int unsigned ADDR_W     = 7,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned OPC_W      = 4,
    parameter int unsigned OPC_LSB    = 11,
    parameter int unsigned MAP_SHIFT  = 2,
    parameter int unsigned FETCH_ADDR = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        br_kind,
    input logic [1:0]        cond_sel,
    input logic [ADDR_W-1:0] target_addr,
    input logic [DATA_W-1:0] instr_word,
    input logic [ADDR_W-1:0] ctrl_addr
);
    localparam int unsigned IND_BIT = DATA_W - 1;

    p_reset_addr_r1: assert property (@(posedge clk)
        rst |=> ctrl_addr == ADDR_W'(FETCH_ADDR));

    p_jump_taken_r2: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b00 && cond_sel == 2'b00) |=> ctrl_addr == $past(target_addr));

    p_not_taken_r3: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b00 && cond_sel == 2'b01 && !instr_word[IND_BIT])
        |=> ctrl_addr == ADDR_W'($past(ctrl_addr) + ADDR_W'(1)));

    p_call_return_r5: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b01 && cond_sel == 2'b00) ##1 (br_kind == 2'b10)
        |=> ctrl_addr == ADDR_W'($past(ctrl_addr, 2) + ADDR_W'(1)));

    p_map_slot_r6: assert property (@(posedge clk) disable iff (rst)
        (br_kind == 2'b11)
        |=> (ctrl_addr[MAP_SHIFT +: OPC_W] == $past(instr_word[OPC_LSB +: OPC_W]))
            && (ctrl_addr[MAP_SHIFT-1:0] == '0)
            && (ctrl_addr[ADDR_W-1] == 1'b0));
endmodule

bind umseq_sequencer umseq_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .OPC_W      (OPC_W),
    .OPC_LSB    (OPC_LSB),
    .MAP_SHIFT  (MAP_SHIFT),
    .FETCH_ADDR (FETCH_ADDR)
) u_umseq_checker (
    .clk         (clk),
    .rst         (rst),
    .br_kind     (br_kind),
    .cond_sel    (cond_sel),
    .target_addr (target_addr),
    .instr_word  (instr_word),
    .ctrl_addr   (ctrl_addr)
);

// File: tb/tb_umseq_sequencer.sv
module tb_umseq_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  br_kind = 2'b00;
    logic [1:0]  cond_sel = 2'b00;
    logic [6:0]  target_addr = '0;
    logic [15:0] instr_word = '0;
    logic        acc_sign = 1'b0;
    logic        acc_zero = 1'b0;
    logic [6:0]  ctrl_addr;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [6:0] exp_car, exp_sbr;

    umseq_sequencer dut (
        .clk(clk), .rst(rst), .br_kind(br_kind), .cond_sel(cond_sel),
        .target_addr(target_addr), .instr_word(instr_word),
        .acc_sign(acc_sign), .acc_zero(acc_zero), .ctrl_addr(ctrl_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: ctrl_addr=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R7 selector encoding
    function automatic logic pick(input logic [1:0] cs, input logic [15:0] dw,
                                  input logic s, input logic z);
        case (cs)
            2'b00:   return 1'b1;
            2'b01:   return dw[15];
            2'b10:   return s;
            default: return z;
        endcase
    endfunction

    // apply one microinstruction, wait one edge, compare against the model
    task automatic step(input logic [1:0] br, input logic [1:0] cs, input logic [6:0] ad,
                        input logic [15:0] dw, input logic s, input logic z, input string req);
        logic t;
        logic [6:0] nxt;
        t = pick(cs, dw, s, z);
        case (br)
            2'b00: nxt = t ? ad : 7'(exp_car + 7'd1);
            2'b01: begin
                nxt = t ? ad : 7'(exp_car + 7'd1);
                if (t) exp_sbr = 7'(exp_car + 7'd1);
            end
            2'b10: nxt = exp_sbr;
            default: nxt = {1'b0, dw[14:11], 2'b00};
        endcase
        exp_car = nxt;
        br_kind = br; cond_sel = cs; target_addr = ad;
        instr_word = dw; acc_sign = s; acc_zero = z;
        @(negedge clk);
        check(req, ctrl_addr, exp_car);
    endtask

    // behavioural micro-ROM: {cond, branch, address}
    function automatic logic [10:0] urom(input logic [6:0] a);
        case (a)
            7'd64:   return {2'b00, 2'b00, 7'd65};
            7'd65:   return {2'b00, 2'b00, 7'd66};
            7'd66:   return {2'b00, 2'b11, 7'd0};
            7'd8:    return {2'b01, 2'b01, 7'd67};
            7'd67:   return {2'b00, 2'b00, 7'd68};
            7'd68:   return {2'b00, 2'b10, 7'd0};
            default: return {2'b00, 2'b00, 7'd64};
        endcase
    endfunction

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : stim
        logic [10:0] w;
        logic [6:0]  trace [0:7];
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_car = 7'd64; exp_sbr = 7'd0;
        check("R1 reset address", ctrl_addr, 7'd64);
        step(2'b10, 2'b00, 7'd5, 16'h0, 1'b0, 1'b0, "R1 cleared return register");
        check("R1 return after reset", ctrl_addr, 7'd0);

        // R8 wrap
        step(2'b00, 2'b00, 7'd127, 16'h0, 1'b0, 1'b0, "R2 jump to top");
        step(2'b00, 2'b01, 7'd9, 16'h0, 1'b0, 1'b0, "R8 wrap");
        check("R8 wrap to zero", ctrl_addr, 7'd0);

        // near-exhaustive sweep
        for (int start = 0; start < 128; start += 9) begin
            for (int br = 0; br < 4; br++) begin
                for (int cs = 0; cs < 4; cs++) begin
                    for (int tv = 0; tv < 2; tv++) begin
                        logic [6:0]  st, ad;
                        logic [15:0] dw;
                        logic        s, z;
                        string       tag;
                        st = (start > 126) ? 7'd127 : 7'(start);
                        if (start == 126) st = 7'd127;
                        ad = st ^ 7'h55;
                        dw = {(cs == 1) ? tv[0] : ~tv[0], st[3:0] ^ 4'(br), 11'h2A5};
                        s  = (cs == 2) ? tv[0] : ~tv[0];
                        z  = (cs == 3) ? tv[0] : ~tv[0];
                        case (br)
                            0: tag = "R2/R3/R7 jump";
                            1: tag = "R3/R4/R7 call";
                            2: tag = "R5 return";
                            default: tag = "R6 map";
                        endcase
                        step(2'b00, 2'b00, st, 16'h0, 1'b0, 1'b0, "R2 setup jump");
                        step(2'(br), 2'(cs), ad, dw, s, z, tag);
                        step(2'b10, 2'(cs), 7'd3, 16'h0, 1'b0, 1'b0, "R9 return register");
                    end
                end
            end
        end

        // R10 fetch routine with indirect call (opcode 2, indirect bit set)
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_car = 7'd64; exp_sbr = 7'd0;
        check("R1 second reset", ctrl_addr, 7'd64);
        trace[0] = 7'd65; trace[1] = 7'd66; trace[2] = 7'd8; trace[3] = 7'd67;
        trace[4] = 7'd68; trace[5] = 7'd9; trace[6] = 7'd64; trace[7] = 7'd65;
        for (int i = 0; i < 8; i++) begin
            w = urom(ctrl_addr);
            step(w[8:7], w[10:9], w[6:0], 16'h9000, 1'b0, 1'b0, "R10 model");
            check("R10 fetch trace", ctrl_addr, trace[i]);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule